// File: doc/BRIEF.md
# Vehicle intrusion alarm controller

This block is a clocked controller for a car guard system. It watches a hidden arm toggle switch, a single door-open line (every door, the hood and the tailgate contact wired in parallel), an owner disarm input and a slow timebase tick. It reports one of three modes: guard off, guard on, or alarm. All time is counted in seconds, and a second is a set number of timebase ticks.

Turning the arm switch on starts an exit delay. If the door line is still active when the delay runs out, the controller drops back to guard off. Otherwise it starts guarding. An intrusion while guarding starts an alarm. The alarm begins with a cancel window, in which the owner can disarm, and then runs a fixed extension. After that the controller re-arms, or it starts a new alarm cycle if the door is still open. The owner disarm input, or turning the arm switch off, returns the controller to guard off from any mode.

The states are OFF (guard off, idle), EXIT (exit delay, guard-off output), ARMED (guard on), AL_WIN (alarm, cancel window) and AL_EXT (alarm, extension). The transitions are:
- OFF→EXIT: on an arm-switch rising edge.
- EXIT→ARMED: when the delay ends with the door closed.
- EXIT→OFF: when the delay ends with the door open.
- ARMED→AL_WIN: when the debounced door line goes active.
- AL_WIN→AL_EXT: when the window ends.
- AL_EXT→ARMED: when the extension ends with the door closed.
- AL_EXT→AL_WIN: when the extension ends with the door open.
- any→OFF: on disarm, on the arm switch being off, or from an illegal state.

Top module: `car_guard_ctrl`

## Requirements
- R1: After reset the controller is in guard off: guard_off_o=1, guard_on_o=0, alarm_o=0.
- R2: Exactly one of guard_on_o and guard_off_o is high in every cycle, and alarm_o high implies guard_on_o high.
- R3: An arm-switch rising edge starts an exit delay of EXIT_SEC seconds. During the delay guard_off_o stays high.
- R4: If the debounced door line is active when the exit delay ends, the controller returns to guard off and does not raise the alarm.
- R5: If the door line is inactive when the exit delay ends, the controller goes to guard on.
- R6: While guarding, a debounced door-open event moves the controller to alarm on the next clock, with alarm_o high.
- R7: The alarm lasts WIN_SEC seconds of cancel window plus EXT_SEC seconds of extension. It then returns to guard on if the door is closed.
- R8: If the door is still open when the extension ends, a new alarm cycle starts and alarm_o stays high.
- R9: A synchronised owner disarm forces guard off on the next clock from any state and clears the alarm.
- R10: The arm switch being off forces guard off and clears all running timers, so a later arm-on starts a full exit delay.
- R11: A door pulse shorter than DEB_TICKS ticks is ignored and does not start an alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase enable pulse; one tick advances debounce and prescaler |
| arm_sw_i | input | 1 | Arm toggle switch level, 1 = on |
| door_open_i | input | 1 | Combined door/hood/tailgate contact, 1 = some opening open |
| disarm_i | input | 1 | Owner disarm/reset, 1 = active |
| guard_on_o | output | 1 | Guarding (also high during alarm) |
| guard_off_o | output | 1 | Not guarding (idle or exit delay) |
| alarm_o | output | 1 | Alarm sounding |

## Verification
The bench builds the controller with TICKS_PER_SEC=4, EXIT_SEC=6, WIN_SEC=2, EXT_SEC=3 and DEB_TICKS=3, and holds tick_i high. One second is then four clocks and a full alarm cycle is twenty clocks. These values let the bench cover the failed exit, repeated alarm cycles, re-arming and timer clearing in a few hundred cycles. The 3-tick debounce keeps 1- and 2-cycle random door glitches below the acceptance threshold, while door openings of 8 cycles or more are clearly accepted.

// File: rtl/cg_pkg.sv
package cg_pkg;
    typedef enum logic [4:0] {
        ST_OFF    = 5'b00001,
        ST_EXIT   = 5'b00010,
        ST_ARMED  = 5'b00100,
        ST_AL_WIN = 5'b01000,
        ST_AL_EXT = 5'b10000
    } guard_state_t;
endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/cg_debounce.sv
module cg_debounce #(
    parameter int DEB_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic din,
    output logic dout
);
    localparam int CW = (DEB_TICKS > 1) ? $clog2(DEB_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            dout <= 1'b0;
        end else if (din == dout) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == LAST) begin
                dout <= din;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cg_prescale.sv
module cg_prescale #(
    parameter int TICKS_PER_SEC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clr,
    output logic sec_p
);
    localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt;

    assign sec_p = tick && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clr)   cnt <= '0;
        else if (sec_p) cnt <= '0;
        else if (tick)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/car_guard_ctrl.sv
module car_guard_ctrl
    import cg_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1000,
    parameter int EXIT_SEC      = 60,
    parameter int WIN_SEC       = 5,
    parameter int EXT_SEC       = 20,
    parameter int DEB_TICKS     = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic arm_sw_i,
    input  logic door_open_i,
    input  logic disarm_i,
    output logic guard_on_o,
    output logic guard_off_o,
    output logic alarm_o
);
    localparam int MAX_SEC = (EXIT_SEC > WIN_SEC)
                           ? ((EXIT_SEC > EXT_SEC) ? EXIT_SEC : EXT_SEC)
                           : ((WIN_SEC > EXT_SEC) ? WIN_SEC : EXT_SEC);
    localparam int SW = $clog2(MAX_SEC + 1);

    guard_state_t state, nxt;
    logic [2:0]   sync_q;
    logic         arm_s, door_s, dis_s, arm_d, arm_rise;
    logic         door_db, sec_p, chg, done;
    logic [SW-1:0] sec_cnt, limit;

    cg_sync #(.W(3)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({arm_sw_i, door_open_i, disarm_i}), .q(sync_q)
    );
    assign {arm_s, door_s, dis_s} = sync_q;

    cg_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
        .clk(clk), .rst_n(rst_n), .tick(tick_i), .din(door_s), .dout(door_db)
    );

    cg_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick_i), .clr(chg), .sec_p(sec_p)
    );

    // Arm-switch edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arm_d <= 1'b0;
        else        arm_d <= arm_s;
    end
    assign arm_rise = arm_s && !arm_d;

    // Period limit for the current timed state
    always_comb begin
        unique case (state)
            ST_EXIT:   limit = SW'(EXIT_SEC);
            ST_AL_WIN: limit = SW'(WIN_SEC);
            ST_AL_EXT: limit = SW'(EXT_SEC);
            default:   limit = SW'(1);
        endcase
    end
    assign done = sec_p && (sec_cnt == limit - 1'b1);
    assign chg  = (nxt != state);

    // Seconds counter, cleared on every state change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sec_cnt <= '0;
        else if (chg)   sec_cnt <= '0;
        else if (sec_p) sec_cnt <= sec_cnt + 1'b1;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        if (dis_s || !arm_s) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:    if (arm_rise) nxt = ST_EXIT;
                ST_EXIT:   if (done) nxt = door_db ? ST_OFF : ST_ARMED;
                ST_ARMED:  if (door_db) nxt = ST_AL_WIN;
                ST_AL_WIN: if (done) nxt = ST_AL_EXT;
                ST_AL_EXT: if (done) nxt = door_db ? ST_AL_WIN : ST_ARMED;
                default:   nxt = ST_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // Output decode
    always_comb begin
        guard_on_o  = 1'b0;
        guard_off_o = 1'b1;
        alarm_o     = 1'b0;
        unique case (state)
            ST_ARMED: begin
                guard_on_o  = 1'b1;
                guard_off_o = 1'b0;
            end
            ST_AL_WIN, ST_AL_EXT: begin
                guard_on_o  = 1'b1;
                guard_off_o = 1'b0;
                alarm_o     = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cg_checker.sv
module cg_checker (
    input logic clk,
    input logic rst_n,
    input logic arm_s,
    input logic dis_s,
    input logic door_db,
    input logic guard_on,
    input logic guard_off,
    input logic alarm
);
    AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        guard_on ^ guard_off); // R2

    AST_ALARM_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |-> guard_on); // R2

    AST_DISARM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        dis_s |=> guard_off && !alarm); // R9

    AST_SWITCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_s |=> guard_off); // R10

    AST_INTRUSION: assert property (@(posedge clk) disable iff (!rst_n)
        (guard_on && !alarm && door_db && arm_s && !dis_s) |=> alarm); // R6
endmodule

bind car_guard_ctrl cg_checker u_chk (
    .clk(clk), .rst_n(rst_n), .arm_s(arm_s), .dis_s(dis_s), .door_db(door_db),
    .guard_on(guard_on_o), .guard_off(guard_off_o), .alarm(alarm_o)
);

// File: tb/car_guard_ctrl_test.sv
module car_guard_ctrl_test;
    localparam int TPS = 4;
    localparam int EXS = 6;
    localparam int WNS = 2;
    localparam int XTS = 3;
    localparam int DEB = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b1;
    logic arm_sw_i = 1'b0;
    logic door_open_i = 1'b0;
    logic disarm_i = 1'b0;
    logic guard_on_o, guard_off_o, alarm_o;
    int   errors = 0;
    int   checks = 0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    car_guard_ctrl #(
        .TICKS_PER_SEC(TPS), .EXIT_SEC(EXS), .WIN_SEC(WNS),
        .EXT_SEC(XTS), .DEB_TICKS(DEB)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .arm_sw_i(arm_sw_i),
        .door_open_i(door_open_i), .disarm_i(disarm_i),
        .guard_on_o(guard_on_o), .guard_off_o(guard_off_o), .alarm_o(alarm_o)
    );

    function automatic int exit_cycles();
        return EXS * TPS;
    endfunction

    function automatic int alarm_cycles();
        return (WNS + XTS) * TPS;
    endfunction

    // expected {guard_on, guard_off, alarm} for a mode: 0 off, 1 guard, 2 alarm
    function automatic logic [2:0] mode_bits(int m);
        case (m)
            1:       return 3'b100;
            2:       return 3'b101;
            default: return 3'b010;
        endcase
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, int mode);
        logic [2:0] act;
        logic [2:0] exp;
        act = {guard_on_o, guard_off_o, alarm_o};
        exp = mode_bits(mode);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {on,off,alarm} actual=%b expected=%b at %0t",
                     req, act, exp, $time);
        end
    endtask

    // arm from idle with door closed and wait until guarding
    task automatic arm_up();
        arm_sw_i = 1'b0;
        step(4);
        arm_sw_i = 1'b1;
        step(exit_cycles() + 8);
    endtask

    initial begin
        int n;
        void'($urandom(32'd1234));
        step(3);
        chk("R1", 0);
        rst_n = 1'b1;
        step(2);
        chk("R1", 0);

        // R4: exit delay ends with door open
        door_open_i = 1'b1;
        arm_sw_i    = 1'b1;
        step(10);
        chk("R3", 0);
        step(exit_cycles() + 6);
        chk("R4", 0);

        // R3/R5: clean exit delay
        door_open_i = 1'b0;
        arm_sw_i    = 1'b0;
        step(4);
        arm_sw_i = 1'b1;
        step(exit_cycles() - 2);
        chk("R3", 0);
        step(8);
        chk("R5", 1);

        // R11: random short glitches
        for (int i = 0; i < 20; i++) begin
            door_open_i = 1'b1;
            step($urandom_range(1, DEB - 1));
            door_open_i = 1'b0;
            step($urandom_range(6, 10));
        end
        step(4);
        chk("R11", 1);

        // R6/R7: intrusion, door closes quickly
        door_open_i = 1'b1;
        step(8);
        chk("R6", 2);
        door_open_i = 1'b0;
        step(10);
        chk("R7", 2);
        step(alarm_cycles() - 8);
        chk("R7", 1);

        // R8: door held open across the extension end
        door_open_i = 1'b1;
        step(alarm_cycles() + 10);
        chk("R8", 2);

        // R9: owner disarm during alarm
        disarm_i = 1'b1;
        step(4);
        chk("R9", 0);
        disarm_i    = 1'b0;
        door_open_i = 1'b0;
        step(4);
        chk("R9", 0);

        // R9: disarm while guarding
        arm_up();
        chk("R5", 1);
        disarm_i = 1'b1;
        step(4);
        chk("R9", 0);
        disarm_i = 1'b0;

        // R10: switch off while guarding
        arm_up();
        arm_sw_i = 1'b0;
        step(4);
        chk("R10", 0);

        // R10: switch off mid exit delay clears timer
        arm_sw_i = 1'b1;
        step(exit_cycles() - 6);
        arm_sw_i = 1'b0;
        step(4);
        arm_sw_i = 1'b1;
        step(exit_cycles() - 2);
        chk("R10", 0);
        step(8);
        chk("R10", 1);

        // constrained-random intrusions
        for (int i = 0; i < 4; i++) begin
            n = $urandom_range(8, 12);
            door_open_i = 1'b1;
            step(8);
            chk("R6", 2);
            step(n - 8);
            door_open_i = 1'b0;
            step(alarm_cycles() + 12 - n);
            chk("R7", 1);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule